// File: doc/BRIEF.md
# Latchable Free-Running Counter Snapshot

This block keeps a wide counter that advances by one on every clock edge after reset, and lets software freeze a copy of it. Writing a command word to the control register with the capture bit set copies the whole live count into a pair of snapshot words in one edge. Writing the clear bit zeroes the snapshot pair instead. Both command bits act once and are never stored, so they always read back as zero.

Software reads the snapshot words afterwards, one word at a time, through a plain synchronous register port. Because both halves come from the same edge, the two reads always form one coherent wide value, whatever the live counter does in between. The snapshot words can also be written directly, for example to seed a known value, and read back. The counter's width is the word width times the number of snapshot words. The read path is either combinational or one register deep, chosen by a parameter.

Top module: `snap_latch_counter`

Address map (default 32-bit words, two snapshot words): address 0 is the control register, address 1 holds the least significant snapshot word, address 2 the most significant one, and address 3 is unmapped. In the control word, bit 0 is the clear command and bit 1 is the capture command.

## Requirements
- R1: While reset is asserted, the control register and both snapshot words read as zero.
- R2: The live count advances by exactly one per clock edge out of reset. Two captures taken N cycles apart differ by N. The clear command never alters the live count.
- R3: A write to address 0 with bit 1 set loads the snapshot pair with the live count held during that write cycle. The low word goes to address 1 and the high word to address 2, both on the same edge.
- R4: Bit 1 of the control register always reads back as 0 after a write, whatever value was written to it.
- R5: A write to address 0 with bit 0 set zeroes both snapshot words, and bit 0 then reads back as 0.
- R6: A write to address 0 with both bits 0 and 1 set leaves both snapshot words at zero.
- R7: Writes to address 1 or address 2 replace only that snapshot word, which then reads back the written value. The other word keeps its value.
- R8: Control bits 31 down to 2 store the written value and read it back unchanged.
- R9: A write to address 3 changes no register, and a read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | ADDR_W (2) | Register address, shared by reads and writes |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_data_o | output | DATA_W (32) | Read data for addr_i (combinational by default) |

## Verification
The assertions take for granted that a command and a direct snapshot write can never reach the storage in the same cycle. The bench keeps to this because the port carries one address per cycle, so every operation it drives is a single write or a single read. The capture-coherence property also relies on the live count being sampled on the write edge itself. The bench therefore holds each address and data stable from one falling edge to the next, so every capture sees exactly one count value. The reference model counts rising edges out of reset and makes no assumption about when software reads the pair.

// File: rtl/snap_pkg.sv
package snap_pkg;

   // Control word command bits (positions are software visible)
   localparam int unsigned CMD_CLR_POS = 0;
   localparam int unsigned CMD_CAP_POS = 1;
   localparam int unsigned CMD_BITS    = 2;

   // Address of the control register; snapshot word k sits at k + 1
   localparam int unsigned ADDR_CTRL      = 0;
   localparam int unsigned ADDR_WORD_BASE = 1;

   typedef struct packed {
      logic cap;
      logic clr;
   } snap_cmd_t;

endpackage

// File: rtl/snap_free_counter.sv
module snap_free_counter #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] cnt_o
);

   initial begin
      assert (CNT_W >= 2) else $error("snap_free_counter: CNT_W too small");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/snap_ctrl_reg.sv
module snap_ctrl_reg
   import snap_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output snap_cmd_t         cmd_o,
   output logic [DATA_W-1:0] ctrl_o
);

   initial begin
      assert (DATA_W > CMD_BITS) else $error("snap_ctrl_reg: DATA_W must exceed command bits");
   end

   localparam logic [DATA_W-1:0] CMD_MASK =
      (DATA_W'(1) << CMD_CLR_POS) | (DATA_W'(1) << CMD_CAP_POS);

   logic [DATA_W-1:0] ctrl_q;

   // Commands act on the write edge itself; they are never stored
   always_comb begin
      cmd_o.cap = wr_i & wdata_i[CMD_CAP_POS];
      cmd_o.clr = wr_i & wdata_i[CMD_CLR_POS];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   ctrl_q <= '0;
      else if (wr_i) ctrl_q <= wdata_i & ~CMD_MASK;
   end

   assign ctrl_o = ctrl_q;

   AST_CTRL_KEEPS_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> ((ctrl_o & ~CMD_MASK) == ($past(wdata_i) & ~CMD_MASK))); // R8

endmodule

// File: rtl/snap_hold_reg.sv
module snap_hold_reg
   import snap_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWORDS = 2,
   localparam int unsigned CNT_W = DATA_W * NWORDS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  snap_cmd_t         cmd_i,
   input  logic [CNT_W-1:0]  live_i,
   input  logic [NWORDS-1:0] word_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  snap_o
);

   initial begin
      assert (NWORDS >= 1) else $error("snap_hold_reg: NWORDS must be at least 1");
   end

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      logic [DATA_W-1:0] word_q;

      // clear wins over capture, capture over direct write
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)           word_q <= '0;
         else if (cmd_i.clr)    word_q <= '0;
         else if (cmd_i.cap)    word_q <= live_i[k*DATA_W +: DATA_W];
         else if (word_we_i[k]) word_q <= wdata_i;
      end

      assign snap_o[k*DATA_W +: DATA_W] = word_q;

      AST_WORD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (word_we_i[k] && !cmd_i.cap && !cmd_i.clr) |=> (word_q == $past(wdata_i))); // R7
   end

   AST_CAPTURE_COHERENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i.cap && !cmd_i.clr) |=> (snap_o == $past(live_i))); // R3

   AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i.clr |=> (snap_o == '0)); // R6

   AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cmd_i.cap && !cmd_i.clr && (word_we_i == '0)) |=> $stable(snap_o)); // R9

endmodule

// File: rtl/snap_latch_counter.sv
module snap_latch_counter
   import snap_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWORDS = 2,
   parameter int unsigned ADDR_W = 2,
   parameter bit          RD_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int unsigned CNT_W = DATA_W * NWORDS;

   initial begin
      assert ((2 ** ADDR_W) >= (NWORDS + 1)) else $error("snap_latch_counter: ADDR_W too narrow");
   end

   logic              ctrl_sel;
   logic [NWORDS-1:0] word_sel;
   logic [CNT_W-1:0]  live_cnt;
   logic [CNT_W-1:0]  snap_val;
   logic [DATA_W-1:0] ctrl_val;
   logic [DATA_W-1:0] rd_mux;
   snap_cmd_t         cmd;

   assign ctrl_sel = (addr_i == ADDR_W'(ADDR_CTRL));

   for (genvar k = 0; k < NWORDS; k++) begin : g_dec
      assign word_sel[k] = (addr_i == ADDR_W'(ADDR_WORD_BASE + k));
   end

   snap_free_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_o  (live_cnt)
   );

   snap_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i & ctrl_sel),
      .wdata_i (wr_data_i),
      .cmd_o   (cmd),
      .ctrl_o  (ctrl_val)
   );

   snap_hold_reg #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_hold (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_i     (cmd),
      .live_i    (live_cnt),
      .word_we_i (word_sel & {NWORDS{wr_en_i}}),
      .wdata_i   (wr_data_i),
      .snap_o    (snap_val)
   );

   always_comb begin
      rd_mux = '0;
      if (ctrl_sel) rd_mux = ctrl_val;
      for (int k = 0; k < NWORDS; k++) begin
         if (word_sel[k]) rd_mux = snap_val[k*DATA_W +: DATA_W];
      end
   end

   if (RD_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) rd_q <= '0;
         else         rd_q <= rd_mux;
      end
      assign rd_data_o = rd_q;
   end else begin : g_rd_comb
      assign rd_data_o = rd_mux;

      AST_CMD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ctrl_sel |-> (rd_data_o[CMD_CAP_POS] == 1'b0 && rd_data_o[CMD_CLR_POS] == 1'b0)); // R4
   end

endmodule

// File: tb/tb_snap_latch_counter.sv
module tb_snap_latch_counter;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // reference model state
   longint unsigned live_m = 0;
   logic [DW-1:0] ctrl_m = '0, lo_m = '0, hi_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   snap_latch_counter #(.DATA_W(DW), .NWORDS(2), .ADDR_W(AW)) dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .addr_i    (addr),
      .wr_data_i (wdata),
      .rd_data_o (rdata)
   );

   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      case (a)
         2'd0:    return ctrl_m;
         2'd1:    return lo_m;
         2'd2:    return hi_m;
         default: return '0;
      endcase
   endfunction

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, got, exp);
      end
   endtask

   // one clock: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic cyc(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
      wr_en = we; addr = a; wdata = d;
      @(posedge clk);
      if (we) begin
         case (a)
            2'd0: begin
               ctrl_m = d & ~32'h3;
               if (d[1]) begin lo_m = live_m[31:0]; hi_m = live_m[63:32]; end
               if (d[0]) begin lo_m = '0; hi_m = '0; end
            end
            2'd1: lo_m = d;
            2'd2: hi_m = d;
            default: ;
         endcase
      end
      live_m++;
      @(negedge clk);
      check(req, rdata, model_read(a));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_1234;
      // R1: reset values on every address
      repeat (3) @(negedge clk);
      for (int a = 0; a < 4; a++) begin
         addr = AW'(a);
         #1 check("R1", rdata, 32'h0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      live_m = 0;

      cyc(0, 0, 0, "R1");
      cyc(0, 1, 0, "R1");
      cyc(0, 2, 0, "R1");
      // R3: capture, then both words
      cyc(1, 0, 32'h2, "R4");
      cyc(0, 1, 0, "R3");
      cyc(0, 2, 0, "R3");
      // R8 and R4: upper fields kept, capture bit not stored
      cyc(1, 0, 32'hA5A5_00F2, "R8");
      cyc(0, 0, 0, "R4");
      // R2: second capture after idle gap
      repeat (37) cyc(0, 3, 0, "R9");
      cyc(1, 0, 32'h2, "R2");
      cyc(0, 1, 0, "R2");
      // R5: clear
      cyc(1, 0, 32'h1, "R5");
      cyc(0, 1, 0, "R5");
      cyc(0, 2, 0, "R5");
      // R7: direct writes
      cyc(1, 1, 32'hDEAD_BEEF, "R7");
      cyc(1, 2, 32'h1234_5678, "R7");
      cyc(0, 1, 0, "R7");
      // R6: both commands
      cyc(1, 0, 32'h3, "R6");
      cyc(0, 1, 0, "R6");
      cyc(0, 2, 0, "R6");
      // R9: unmapped write ignored
      cyc(1, 1, 32'h0BAD_F00D, "R7");
      cyc(1, 3, 32'hFFFF_FFFF, "R9");
      cyc(0, 0, 0, "R9");
      cyc(0, 1, 0, "R9");
      cyc(0, 2, 0, "R9");
      // R7: capture then overwrite low only, high untouched
      cyc(1, 0, 32'h2, "R3");
      cyc(1, 1, 32'h5555_AAAA, "R7");
      cyc(0, 2, 0, "R7");
      // R2: clear never disturbs live count (capture after clear)
      cyc(1, 0, 32'h1, "R2");
      cyc(1, 0, 32'h2, "R2");
      cyc(0, 1, 0, "R2");
      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         cyc(lfsr[4], lfsr[1:0], {lfsr[31:2], lfsr[6:5]}, "R3");
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule